// File: doc/BRIEF.md
# Serial PROM Bit-Bang Access Port

This block lets host software reach an external three-wire serial PROM through a memory port that other traffic also uses. Software writes a single 8-bit control register. Setting the request field asks for the port. Once the port reports no other traffic, the block takes ownership, reports the grant on its memory-port side, and sets a ready flag in the register.

While the port is owned, three register fields drive the chip-select, serial clock and serial data-out pins directly. The serial data-in pin is brought back, through a two-stage synchronizer, into a read-only field. The software runs the PROM command protocol by toggling these fields.

The ready flag also works as a settle timer. Every register write made while the port is owned clears ready. Ready comes back after a fixed 800 ns, counted in clock cycles. The one exception is the write that first grants the port: there, ready rises at the grant and carries no delay. Clearing the request field gives the port back and forces the chip-select and clock pins low.

Top module: `serial_prom_access`

## Requirements
- R1: After reset, the register reads 0x00, `port_grant` is low, and the `prom_cs`, `prom_sck` and `prom_mosi` pins are low.
- R2: With the request field (register bit 5) set, `port_grant` rises only on a clock edge where `port_busy` was low. While `port_busy` stays high, the grant is withheld.
- R3: In the cycle `port_grant` first goes high, the ready field (bit 4) reads 1, with no settle delay.
- R4: While granted, the pins follow the stored fields: chip select from bit 3, clock from bit 2 and data out from bit 1. Before the grant, these pins stay low even when those fields have been written to 1.
- R5: A write with bit 5 set, made while granted, clears ready from the next cycle for exactly SETTLE_CYC cycles. Ready then reads 1 again.
- R6: SETTLE_CYC equals ceil(CLK_MHZ * SETTLE_NS / 1000). With CLK_MHZ=250 and SETTLE_NS=800, this is 200 cycles.
- R7: A write during a settle window restarts the full SETTLE_CYC count from that write.
- R8: A write with bit 5 clear ends the grant on the next edge. It also clears the stored chip-select, clock and data-out fields, so a later grant starts with those pins low.
- R9: Register bit 0 shows `prom_miso` two clock edges after the pin changes, while the port is granted.
- R10: Bits 4 and 0 are read-only. Bits 7 and 6 read 0. Write data in these bit positions has no effect.
- R11: Once granted, the grant holds while `port_busy` rises, until software clears the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value: {2'b0, req, ready, cs, clk, dout, din} |
| port_busy | input | 1 | Memory port is serving other traffic |
| port_grant | output | 1 | Block currently owns the memory port |
| prom_cs | output | 1 | PROM chip select |
| prom_sck | output | 1 | PROM serial clock |
| prom_mosi | output | 1 | PROM serial data out |
| prom_miso | input | 1 | PROM serial data in |

## Verification
The bench builds the block with CLK_MHZ=250 and SETTLE_NS=800, which matches the bench clock. The settle window is therefore 200 cycles. That is short enough to measure the window exactly, cycle by cycle, twice: once straight after a write and once after a restart 50 cycles in. The runs also cover a request held back by a busy port, a grant that survives a later busy period, and a release followed by a fresh grant.

// File: rtl/serial_prom_access.sv
module serial_prom_access #(
  parameter int CLK_MHZ   = 250,
  parameter int SETTLE_NS = 800
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       port_busy,
  output logic       port_grant,
  output logic       prom_cs,
  output logic       prom_sck,
  output logic       prom_mosi,
  input  logic       prom_miso
);

  localparam int SETTLE_CYC = (CLK_MHZ * SETTLE_NS + 999) / 1000;
  localparam int CW         = $clog2(SETTLE_CYC + 1);

  logic          req_q, own_q, cs_q, ck_q, do_q;
  logic          din_s1, din_s2;
  logic [CW-1:0] settle_q;
  logic          ready, wr_req, wr_rel;

  assign wr_req = wr_en &  wr_data[5];
  assign wr_rel = wr_en & ~wr_data[5];
  assign ready  = own_q && (settle_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q    <= 1'b0;
      own_q    <= 1'b0;
      cs_q     <= 1'b0;
      ck_q     <= 1'b0;
      do_q     <= 1'b0;
      settle_q <= '0;
    end else begin
      if (wr_en) begin
        req_q <= wr_data[5];
        cs_q  <= wr_data[5] & wr_data[3];
        ck_q  <= wr_data[5] & wr_data[2];
        do_q  <= wr_data[5] & wr_data[1];
      end
      if (wr_rel)
        own_q <= 1'b0;
      else if (req_q && !own_q && !port_busy)
        own_q <= 1'b1;
      if (wr_rel)
        settle_q <= '0;
      else if (wr_req && own_q)
        settle_q <= CW'(SETTLE_CYC);
      else if (settle_q != '0)
        settle_q <= settle_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      din_s1 <= 1'b0;
      din_s2 <= 1'b0;
    end else begin
      din_s1 <= prom_miso;
      din_s2 <= din_s1;
    end
  end

  assign port_grant = own_q;
  assign prom_cs    = own_q & cs_q;
  assign prom_sck   = own_q & ck_q;
  assign prom_mosi  = own_q & do_q;
  assign rd_data    = {2'b00, req_q, ready, cs_q, ck_q, do_q, own_q & din_s2};

  assert_grant_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_grant) |-> !$past(port_busy));

  assert_grant_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(port_grant) |-> rd_data[4]);

  assert_settle_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && port_grant) |=> !rd_data[4]);

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rel |=> (!port_grant && !prom_cs && !prom_sck));

  assert_sync_R9: assert property (@(posedge clk) disable iff (!rst_n)
    port_grant |-> (rd_data[0] == $past(prom_miso, 2)));

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (port_grant && !wr_rel) |=> port_grant);

endmodule

// File: tb/serial_prom_access_bench.sv
module serial_prom_access_bench;
  localparam int CLK_MHZ   = 250;
  localparam int SETTLE_NS = 800;
  localparam int EXP_CYC   = (CLK_MHZ * SETTLE_NS + 999) / 1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       port_busy = 1'b0;
  logic       port_grant, prom_cs, prom_sck, prom_mosi;
  logic       prom_miso = 1'b0;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  serial_prom_access #(.CLK_MHZ(CLK_MHZ), .SETTLE_NS(SETTLE_NS)) u_serial_prom_access (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .port_busy(port_busy), .port_grant(port_grant), .prom_cs(prom_cs),
    .prom_sck(prom_sck), .prom_mosi(prom_mosi), .prom_miso(prom_miso));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic count_low(input string req, input int exp);
    int low = 0;
    for (int i = 0; i < EXP_CYC + 20; i++) begin
      if (rd_data[4]) break;
      low++;
      @(negedge clk);
    end
    check(req, low, exp);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rd_data", rd_data, 8'h00);
    check("R1 pins", {port_grant, prom_cs, prom_sck, prom_mosi}, 4'b0000);
  endtask

  task automatic t_grant;
    port_busy = 1'b1;
    wr(8'h2E);
    check("R4 pins low before grant", {prom_cs, prom_sck, prom_mosi}, 3'b000);
    repeat (5) @(negedge clk);
    check("R2 grant withheld while busy", port_grant, 0);
    check("R2 ready low before grant", rd_data[4], 0);
    port_busy = 1'b0;
    @(negedge clk);
    check("R2 grant after idle", port_grant, 1);
    check("R3 ready at grant", rd_data[4], 1);
    check("R4 pins follow fields", {prom_cs, prom_sck, prom_mosi}, 3'b111);
    port_busy = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 grant held while busy", port_grant, 1);
    port_busy = 1'b0;
  endtask

  task automatic t_settle;
    wr(8'h26);
    check("R4 pins after write", {prom_cs, prom_sck, prom_mosi}, 3'b011);
    count_low("R5 R6 settle length", EXP_CYC);
    check("R5 ready back", rd_data[4], 1);
  endtask

  task automatic t_restart;
    wr(8'h28);
    repeat (49) @(negedge clk);
    check("R7 still settling", rd_data[4], 0);
    wr(8'h28);
    count_low("R7 restart length", EXP_CYC);
  endtask

  task automatic t_readonly;
    wr(8'hF9);
    check("R10 read-only bits ignored", rd_data, 8'h28);
    repeat (EXP_CYC + 2) @(negedge clk);
    check("R10 after settle", rd_data, 8'h38);
  endtask

  task automatic t_sync;
    prom_miso = 1'b1;
    @(negedge clk);
    check("R9 one edge", rd_data[0], 0);
    @(negedge clk);
    check("R9 two edges", rd_data[0], 1);
    prom_miso = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 falls", rd_data[0], 0);
  endtask

  task automatic t_release;
    wr(8'h0C);
    check("R8 grant released", port_grant, 0);
    check("R8 pins low", {prom_cs, prom_sck, prom_mosi}, 3'b000);
    check("R8 rd_data", rd_data, 8'h00);
    wr(8'h20);
    @(negedge clk);
    check("R8 regrant", port_grant, 1);
    check("R8 fresh grant pins low", {prom_cs, prom_sck}, 2'b00);
    check("R3 ready at regrant", rd_data[4], 1);
  endtask

  initial begin
    t_reset();
    t_grant();
    t_settle();
    t_restart();
    t_readonly();
    t_sync();
    t_release();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule